// File: doc/BRIEF.md
# Two-stage real-time clock prescaler

This block turns the 32768 Hz real-time clock into the enables that a calendar needs. Two reload down-counters run in cascade. The first stage divides the raw clock and produces a one-cycle enable, the stage strobe. The second stage counts only stage strobes and produces the seconds tick. Each divisor is programmed as its factor minus one, in two fields of one configuration word. With the reset values the seconds tick arrives once every 32768 clocks, which is 1 Hz.

A calibration pin can carry one of two square waves: a 512 Hz tap of the first counter, or a 1 Hz wave built from the second stage. An enable bit and a select bit choose what the pin shows. The pin is registered, so changing the select bit cannot produce a glitch. A new configuration word is applied to each counter only at that counter's next reload, so a period in progress is never cut short.

Top module: `rtc_prescaler`

## Requirements
- R1: After reset the first-stage field holds 127 and the second-stage field holds 255, so the readback word is 0x007F00FF.
- R2: The readback word carries the first-stage field in bits 22:16 and the second-stage field in bits 14:0. Bit 15 and bits 31:23 always read zero, and write data in those bits is ignored.
- R3: With a first-stage field value A, `stage_stb_o` is a single-cycle pulse once every A+1 clocks. A value of 0 gives a pulse on every clock.
- R4: With a second-stage field value S, `sec_tick_o` pulses once every (A+1)*(S+1) clocks. It is only ever high in a cycle where `stage_stb_o` is also high.
- R5: With the reset field values, the interval between seconds ticks is exactly 32768 clocks.
- R6: A configuration write does not change the period that a counter is already running. Each counter uses the new value from its next reload onward.
- R7: While `cal_en_i` is 0, `cal_o` is 0 from the clock after the enable went low.
- R8: With `cal_en_i`=1, `cal_sel_i`=0 and the default first-stage field, `cal_o` is a square wave with a period of 64 clocks and a 50 percent duty cycle.
- R9: With `cal_en_i`=1 and `cal_sel_i`=1, `cal_o` toggles twice per second-stage period. When S+1 is even this gives a 50 percent duty cycle (A=3 and S=5 give a period of 24 clocks with 12 high).
- R10: `cal_o` is registered. A change of `cal_en_i` or `cal_sel_i` appears on the pin one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Real-time clock (32768 Hz in use) |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_wdata_i | input | 32 | Configuration word write data |
| cal_en_i | input | 1 | Calibration pin enable |
| cal_sel_i | input | 1 | Calibration source select: 1 for the 1 Hz wave, 0 for the 512 Hz tap |
| stage_stb_o | output | 1 | First-stage one-cycle enable |
| sec_tick_o | output | 1 | Second-stage one-cycle seconds tick |
| cal_o | output | 1 | Calibration pin |
| cfg_rdata_o | output | 32 | Configuration word readback |

## Verification
The assertions check the per-cycle properties on every clock. A counter holds while its enable is low. A pulse never repeats on the next cycle unless the divisor is one. The seconds tick always coincides with a stage strobe. The loaded length changes only at a reload. The calibration pin is low after the enable drops. The readback follows writes.

Some behaviour only the bench scenarios can show, because it depends on absolute periods and duty cycles:
- the intervals of 128 and 32768 clocks;
- the 64-clock square wave and the 24-clock square wave;
- that the period in flight completes at its old length after a write;
- that data in the reserved bits is dropped.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;
  localparam int          WORD_W    = 32;
  localparam int          PRE_W     = 7;
  localparam int          SEC_W     = 15;
  localparam int          PRE_LSB   = 16;
  localparam int          SEC_LSB   = 0;
  localparam int          TAP_BIT   = 5;
  localparam logic [PRE_W-1:0] PRE_RST = 7'd127;
  localparam logic [SEC_W-1:0] SEC_RST = 15'd255;
endpackage

// File: rtl/rtcp_cfg.sv
module rtcp_cfg
  import rtcp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [PRE_W-1:0]  pre_o,
  output logic [SEC_W-1:0]  sec_o,
  output logic [WORD_W-1:0] rdata_o
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [SEC_W-1:0] sec_q, sec_d;

  always_comb begin
    pre_d = pre_q;
    sec_d = sec_q;
    if (we_i) begin
      pre_d = wdata_i[PRE_LSB +: PRE_W];
      sec_d = wdata_i[SEC_LSB +: SEC_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= PRE_RST;
      sec_q <= SEC_RST;
    end else begin
      pre_q <= pre_d;
      sec_q <= sec_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[PRE_LSB +: PRE_W] = pre_q;
    rdata_o[SEC_LSB +: SEC_W] = sec_q;
  end

  assign pre_o = pre_q;
  assign sec_o = sec_q;

  // R2
  wr_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (rdata_o[PRE_LSB +: PRE_W] == $past(wdata_i[PRE_LSB +: PRE_W]))
          && (rdata_o[SEC_LSB +: SEC_W] == $past(wdata_i[SEC_LSB +: SEC_W])));
  // R2
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(rdata_o));
endmodule

// File: rtl/rtcp_divider.sv
module rtcp_divider #(
  parameter int             W       = 7,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] reload_i,
  output logic         tick_o,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] len_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] len_q, len_d;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);
  assign tick_o  = en_i && at_zero;

  always_comb begin
    cnt_d = cnt_q;
    len_d = len_q;
    if (en_i) begin
      if (at_zero) begin
        cnt_d = reload_i;
        len_d = reload_i;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RST_VAL;
      len_q <= RST_VAL;
    end else begin
      cnt_q <= cnt_d;
      len_q <= len_d;
    end
  end

  assign cnt_o = cnt_q;
  assign len_o = len_q;

  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
  // R3
  pulse_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && (reload_i != '0)) |=> !tick_o);
  // R6
  len_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(len_q));
endmodule

// File: rtl/rtcp_calout.sv
module rtcp_calout #(
  parameter int SW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tap_i,
  input  logic          step_i,
  input  logic [SW-1:0] sec_cnt_i,
  input  logic [SW-1:0] sec_len_i,
  input  logic          en_i,
  input  logic          sel_i,
  output logic          cal_o
);
  logic [SW:0] half;
  logic        flip;
  logic        sq_q, sq_d;
  logic        cal_q, cal_d;

  assign half = ({1'b0, sec_len_i} + {{SW{1'b0}}, 1'b1}) >> 1;
  assign flip = step_i && ((sec_cnt_i == '0) || ({1'b0, sec_cnt_i} == half));

  always_comb begin
    sq_d  = sq_q ^ flip;
    cal_d = en_i && (sel_i ? sq_q : tap_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_q  <= 1'b0;
      cal_q <= 1'b0;
    end else begin
      sq_q  <= sq_d;
      cal_q <= cal_d;
    end
  end

  assign cal_o = cal_q;

  // R7
  pin_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !cal_o);
  // R9
  sq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(sq_q));
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtcp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  input  logic              cal_en_i,
  input  logic              cal_sel_i,
  output logic              stage_stb_o,
  output logic              sec_tick_o,
  output logic              cal_o,
  output logic [WORD_W-1:0] cfg_rdata_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic [PRE_W-1:0] pre_val, pre_cnt, pre_len;
  logic [SEC_W-1:0] sec_val, sec_cnt, sec_len;
  logic             stb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  rtcp_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .pre_o   (pre_val),
    .sec_o   (sec_val),
    .rdata_o (cfg_rdata_o)
  );

  rtcp_divider #(.W(PRE_W), .RST_VAL(PRE_RST)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .en_i     (1'b1),
    .reload_i (pre_val),
    .tick_o   (stb),
    .cnt_o    (pre_cnt),
    .len_o    (pre_len)
  );

  rtcp_divider #(.W(SEC_W), .RST_VAL(SEC_RST)) u_sec (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .en_i     (stb),
    .reload_i (sec_val),
    .tick_o   (sec_tick_o),
    .cnt_o    (sec_cnt),
    .len_o    (sec_len)
  );

  rtcp_calout #(.SW(SEC_W)) u_cal (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .tap_i     (pre_cnt[TAP_BIT]),
    .step_i    (stb),
    .sec_cnt_i (sec_cnt),
    .sec_len_i (sec_len),
    .en_i      (cal_en_i),
    .sel_i     (cal_sel_i),
    .cal_o     (cal_o)
  );

  assign stage_stb_o = stb;

  // R4
  tick_in_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    sec_tick_o |-> stage_stb_o);
  // R3
  pre_len_match_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    stage_stb_o |=> (pre_cnt == pre_len));
endmodule

// File: tb/rtc_prescaler_test.sv
module rtc_prescaler_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        cal_en = 1'b0;
  logic        cal_sel = 1'b0;
  logic        stb, tick, cal;
  logic [31:0] rdata;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int a_last, s_last;
  bit a_have = 0, s_have = 0;
  bit done = 0;
  int exp_a[$];
  int exp_s[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rtc_prescaler uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .cal_en_i(cal_en), .cal_sel_i(cal_sel), .stage_stb_o(stb),
    .sec_tick_o(tick), .cal_o(cal), .cfg_rdata_o(rdata)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops expected intervals as pulses arrive
  always @(negedge clk) begin
    if (rst_n) begin
      if (stb) begin
        if (a_have && exp_a.size() > 0) chk("R3", cyc - a_last, exp_a.pop_front());
        a_last = cyc;
        a_have = 1;
      end
      if (tick) begin
        if (s_have && exp_s.size() > 0) chk("R4", cyc - s_last, exp_s.pop_front());
        s_last = cyc;
        s_have = 1;
      end
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic measure(input int n, output int highs, output int rises);
    logic prev;
    highs = 0; rises = 0;
    prev = cal;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cal) highs++;
      if (cal && !prev) rises++;
      prev = cal;
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int hi, ri;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", rdata, 32'h007F00FF);
    chk("R1", stb, 0);
    chk("R1", cal, 0);

    // R3 default 128-clock strobe, R5 32768-clock seconds tick
    repeat (3) exp_a.push_back(128);
    exp_s.push_back(32768);

    // R8 512 Hz tap
    cal_en = 1'b1; cal_sel = 1'b0;
    repeat (2) @(negedge clk);
    measure(256, hi, ri);
    chk("R8", hi, 128);
    chk("R8", ri, 4);
    // R7 pin off
    cal_en = 1'b0;
    repeat (2) @(negedge clk);
    measure(256, hi, ri);
    chk("R7", hi, 0);

    // R2 reserved and upper bits dropped
    wr(32'hFFFF80FF);
    chk("R2", rdata, 32'h007F00FF);

    while (exp_s.size() > 0 || exp_a.size() > 0) @(negedge clk);
    chk("R5", exp_s.size(), 0);

    // R6 write right after a strobe: the running period stays 128
    @(negedge clk);
    while (!stb) @(negedge clk);
    we = 1'b1; wdata = 32'h00038005;
    #1;
    exp_a.push_back(128);
    repeat (3) exp_a.push_back(4);
    @(negedge clk); we = 1'b0;
    chk("R2", rdata, 32'h00030005);
    while (exp_a.size() > 0) @(negedge clk);
    chk("R6", exp_a.size(), 0);

    // R4 seconds tick at (3+1)*(5+1)
    repeat (1300) @(negedge clk);
    s_have = 0;
    repeat (3) exp_s.push_back(24);
    // R9 1 Hz-style square wave
    cal_en = 1'b1; cal_sel = 1'b1;
    repeat (2) @(negedge clk);
    measure(240, hi, ri);
    chk("R9", hi, 120);
    chk("R9", ri, 10);
    while (exp_s.size() > 0) @(negedge clk);

    // R10 select change shows one clock later
    while (!cal) @(negedge clk);
    cal_sel = 1'b0;
    #1;
    chk("R10", cal, 1);
    @(negedge clk);
    chk("R10", cal, 0);
    cal_sel = 1'b1;
    while (!cal) @(negedge clk);
    cal_en = 1'b0;
    @(negedge clk);
    chk("R7", cal, 0);

    // R3 R4 divide by one in both stages
    wr(32'h00000000);
    chk("R2", rdata, 32'h00000000);
    repeat (50) @(negedge clk);
    a_have = 0; s_have = 0;
    repeat (3) exp_a.push_back(1);
    repeat (3) exp_s.push_back(1);
    repeat (10) @(negedge clk);
    chk("R3", exp_a.size(), 0);
    chk("R4", exp_s.size(), 0);
    summary();
  end
endmodule